// File: doc/BRIEF.md
# Sixteen-bit two-level carry-lookahead adder

This block adds two 16-bit unsigned operands and a carry-in, producing a 16-bit sum and a carry-out, entirely in combinational logic. The operands are cut into four 4-bit slices.

Each slice does three things:

- It forms per-bit generate (A AND B) and propagate (A XOR B).
- It computes its internal carries as flattened sum-of-products terms in those signals and its own carry-in.
- It reports a group generate and a group propagate.

A separate second-level lookahead unit uses the same flattened equations, with the group pairs in place of the bit pairs. From these and the global carry-in it produces the carries into slices 1, 2 and 3 and the final carry-out. No carry ripples from one slice to the next.

The block holds no state, so it has no clock, no reset and no state machine. Every output is a pure function of the current inputs.

Top module: `cla16_adder`

## Requirements
- R1: For every input combination, the 17-bit value {carry_out, sum_out} equals a_in + b_in + carry_in.
- R2: With both operands zero, the carry-in alone sets sum_out to 0x0001 and leaves carry_out at 0.
- R3: With a_in = 0xFFFF, b_in = 0x0000 and carry_in = 1, the carry propagates through all four slices: sum_out = 0x0000 and carry_out = 1.
- R4: A carry generated at the top bit of one slice reaches the next slice through the second-level unit. For example, 0x000F + 0x0001 gives 0x0010, and 0x0FFF + 0x0001 gives 0x1000.
- R5: A generate in bit 15 alone sets carry_out. For example, 0x8000 + 0x8000 gives sum 0x0000 and carry_out 1.
- R6: When both operands are 0xFFFF and carry_in is 1, sum_out = 0xFFFF and carry_out = 1.
- R7: When no bit position both generates and propagates out of bit 15, carry_out stays 0. For example, 0x7FFF + 0x0000 + 1 gives 0x8000 with carry_out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The directed patterns pick apart the carry paths:

- A lone carry-in shows that carry_in reaches bit 0.
- All-ones plus a carry-in drives the longest propagate chain through every slice and through the second-level unit.
- Operands that generate exactly at a slice's top bit show whether the carry into the next slice comes from that slice's group generate.
- A generate in bit 15 only, and a value that stops one bit short of overflow, tell a real carry-out apart from a spurious one.

Random operands with random carry-in then cover mixed generate and propagate patterns that no single directed case isolates.

// File: rtl/cla_pkg.sv
package cla_pkg;
    parameter int LA_W = 4;

    // Flattened lookahead: every carry is an OR of product terms in g, p, c0 only.
    function automatic logic [LA_W:0] la_carries(input logic [LA_W-1:0] g,
                                                 input logic [LA_W-1:0] p,
                                                 input logic c0);
        logic [LA_W:0] c;
        logic acc;
        logic prod;
        c[0] = c0;
        for (int k = 0; k < LA_W; k++) begin
            acc = 1'b0;
            for (int j = 0; j <= k; j++) begin
                prod = g[j];
                for (int m = j + 1; m <= k; m++) prod = prod & p[m];
                acc = acc | prod;
            end
            prod = c0;
            for (int m = 0; m <= k; m++) prod = prod & p[m];
            c[k+1] = acc | prod;
        end
        return c;
    endfunction
endpackage

// File: rtl/cla_slice.sv
module cla_slice
    import cla_pkg::*;
(
    input  logic [LA_W-1:0] op_a,
    input  logic [LA_W-1:0] op_b,
    input  logic            c_in,
    output logic [LA_W-1:0] sum,
    output logic            grp_gen,
    output logic            grp_prop
);
    logic [LA_W-1:0] gen, prop;
    logic [LA_W:0]   carry;
    logic [LA_W:0]   gen_only;

    always_comb begin
        gen      = op_a & op_b;
        prop     = op_a ^ op_b;
        carry    = la_carries(gen, prop, c_in);
        sum      = prop ^ carry[LA_W-1:0];
        gen_only = la_carries(gen, prop, 1'b0);
        grp_gen  = gen_only[LA_W];
        grp_prop = &prop;
    end

    // R1: slice's own carry-out agrees with its group signals
    always_comb begin
        if (!$isunknown({op_a, op_b, c_in})) begin
            a_r1_group_carry: assert (carry[LA_W] == (grp_gen | (grp_prop & c_in)))
                else $error("slice group carry mismatch");
            a_r1_group_excl: assert (!(grp_gen && grp_prop))
                else $error("group generate and propagate both set");
        end
    end
endmodule

// File: rtl/cla_unit.sv
module cla_unit
    import cla_pkg::*;
(
    input  logic [LA_W-1:0] grp_gen,
    input  logic [LA_W-1:0] grp_prop,
    input  logic            c0,
    output logic [LA_W:0]   grp_carry
);
    always_comb grp_carry = la_carries(grp_gen, grp_prop, c0);

    // R4: each group carry equals a ripple step from the one below
    always_comb begin
        if (!$isunknown({grp_gen, grp_prop, c0})) begin
            for (int k = 0; k < LA_W; k++) begin
                a_r4_ripple_equiv: assert (grp_carry[k+1] ==
                                           (grp_gen[k] | (grp_prop[k] & grp_carry[k])))
                    else $error("group carry %0d mismatch", k + 1);
            end
        end
    end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
#(
    parameter int SLICES = LA_W,
    localparam int WIDTH = SLICES * LA_W
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    logic [SLICES-1:0] gg, gp;
    logic [SLICES:0]   gc;

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        cla_slice u_slice (
            .op_a     (a_in[s*LA_W +: LA_W]),
            .op_b     (b_in[s*LA_W +: LA_W]),
            .c_in     (gc[s]),
            .sum      (sum_out[s*LA_W +: LA_W]),
            .grp_gen  (gg[s]),
            .grp_prop (gp[s])
        );
    end

    cla_unit u_unit (
        .grp_gen  (gg),
        .grp_prop (gp),
        .c0       (carry_in),
        .grp_carry(gc)
    );

    assign carry_out = gc[SLICES];

    // R1: overall arithmetic result; R7: no spurious carry-out
    always_comb begin
        if (!$isunknown({a_in, b_in, carry_in})) begin
            a_r1_total: assert ({carry_out, sum_out} ==
                                ({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in}))
                else $error("adder total mismatch");
            a_r7_no_false_carry: assert (!(carry_out && !a_in[WIDTH-1] && !b_in[WIDTH-1]))
                else $error("carry-out with both top bits clear");
        end
    end
endmodule

// File: tb/cla16_adder_test.sv
module cla16_adder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a, b;
    logic        ci;
    logic [15:0] s;
    logic        co;
    int          vectors = 0;
    int          miscompares = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    cla16_adder uut (
        .a_in(a), .b_in(b), .carry_in(ci), .sum_out(s), .carry_out(co)
    );

    task automatic apply(input logic [15:0] ta, input logic [15:0] tb_v,
                         input logic tc, input string req);
        int unsigned expv;
        @(posedge clk);
        #1;
        a = ta; b = tb_v; ci = tc;
        expv = int'(ta) + int'(tb_v) + int'(tc);
        @(negedge clk);
        vectors++;
        if ({co, s} !== expv[16:0]) begin
            miscompares++;
            $display("FAIL %s: %h+%h+%b got %b_%h expected %b_%h",
                     req, ta, tb_v, tc, co, s, expv[16], expv[15:0]);
        end
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: zero inputs give zero outputs (R1)
        apply(16'h0000, 16'h0000, 1'b0, "R1 zero");
        apply(16'h0000, 16'h0000, 1'b1, "R2 carry-in only");
        apply(16'hFFFF, 16'h0000, 1'b1, "R3 full propagate");
        apply(16'hFFFF, 16'h0001, 1'b0, "R3 all-ones plus one");
        apply(16'h000F, 16'h0001, 1'b0, "R4 slice0->1");
        apply(16'h00FF, 16'h0001, 1'b0, "R4 slice1->2");
        apply(16'h0FFF, 16'h0001, 1'b0, "R4 slice2->3");
        apply(16'h0008, 16'h0008, 1'b0, "R4 generate at slice top");
        apply(16'h8000, 16'h8000, 1'b0, "R5 top generate");
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R6 max inputs");
        apply(16'h7FFF, 16'h0000, 1'b1, "R7 no carry-out");
        apply(16'h5555, 16'hAAAA, 1'b0, "R7 all propagate no cin");
        apply(16'h5555, 16'hAAAA, 1'b1, "R3 all propagate with cin");
        for (int i = 0; i < 2000; i++)
            apply(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule